// File: doc/BRIEF.md
# Programmable Token Delay Line

The block delays a stream of request tokens by a programmable number of clock cycles. Each token carries one direction bit. The time gaps between tokens come out exactly as they went in. A token is a single cycle with the request input high. Tokens may arrive in any pattern, including on every cycle, and many can be inside the line at the same time. The line never refuses or stalls a token, and it has no handshake in either direction.

The line is a cascade of stages. Each stage holds four delay segments of 2, 4, 8 and 16 cycles. A select bit puts each segment in the path or bypasses it. The total delay D is the sum of the selected segments over all stages, with a range of 0 to 420 cycles at the default fourteen stages. A registered output stage drives a clean one-cycle request pulse for each token. The direction output keeps the bit of the most recent token it delivered.

A new select word is taken only when the line is empty and no token is arriving. This keeps every token in flight on the delay that was active when it entered. A busy output shows that accepted tokens have not yet been delivered.

Top module: `token_delay_line`

## Requirements
- R1: While reset is high and on the first cycle after it, `reqOut`, `upOut` and `busy` are 0 and the active delay is 0.
- R2: A token sampled with `reqIn` high at clock edge t drives `reqOut` high for exactly one cycle, following edge t+D. Select bit 4s+k (k = 0..3) adds 2<<k cycles to D for stage s.
- R3: Tokens separated by any gap, including tokens on consecutive cycles, come out with the same gaps.
- R4: `upOut` takes the `upIn` value sampled with its token on the edge that raises `reqOut` for that token. It holds that value while `reqOut` is low.
- R5: A token presented on every cycle is accepted every cycle and delivered, and none is lost.
- R6: With D = 0, a token sampled at edge t appears on `reqOut` in the cycle right after edge t.
- R7: `delaySel` has no effect while `busy` or `reqIn` is high. The word present is adopted on the first edge at which the line is empty and `reqIn` is low.
- R8: `busy` is high exactly when at least one accepted token has not yet been shown on `reqOut`. While it is low and `reqIn` is low, `reqOut` is low in the next cycle.
- R9: With every select bit set, D is 420 and tokens are delivered 420 edges after entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one delay unit per cycle |
| rst | input | 1 | Synchronous reset, active high |
| reqIn | input | 1 | Token present this cycle |
| upIn | input | 1 | Direction bit of the arriving token |
| delaySel | input | 56 | Segment selects, four bits per stage, stage 0 in the low bits |
| reqOut | output | 1 | One-cycle pulse per delivered token |
| upOut | output | 1 | Direction bit of the last delivered token |
| busy | output | 1 | Tokens are still inside the line |

## Verification
A token is due on `reqOut` after edge t+D, and with D = 0 that is the edge that samples it. `upOut` changes on that same edge. `busy` rises on the edge that accepts a token and falls on the edge that delivers the last one. The bench keeps a behavioural model that adds the active delay to the edge count of each token and updates on every rising edge. It compares all three outputs at the following falling edge, so each result is sampled in the cycle it is due. The model adopts a new select word under the same empty-line rule, so tokens sent across a select change are checked against the delay that was active when they entered.

// File: rtl/tdl_pkg.sv
package tdl_pkg;

  // strobes from control to datapath
  typedef struct packed {
    logic loadCfg;    // adopt a new select word this edge
    logic acceptTok;  // inject a token at the head of the chain
  } tdlStrobe_t;

  // one slot of the delay chain
  typedef struct packed {
    logic vld;
    logic up;
  } tdlTok_t;

endpackage

// File: rtl/tdl_segment.sv
module tdl_segment
  import tdl_pkg::*;
#(
  parameter int LEN = 2
) (
  input  logic    clk,
  input  logic    rst,
  input  logic    bypass,
  input  tdlTok_t segIn,
  output tdlTok_t segOut,
  output logic    segHasTok
);

  tdlTok_t slot [LEN];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < LEN; i++) slot[i] <= '0;
    end else begin
      slot[0] <= bypass ? '0 : segIn;
      for (int i = 1; i < LEN; i++) slot[i] <= slot[i-1];
    end
  end

  assign segOut = bypass ? segIn : slot[LEN-1];

  always_comb begin
    segHasTok = 1'b0;
    for (int i = 0; i < LEN; i++) segHasTok = segHasTok | slot[i].vld;
  end

  // a bypassed, empty segment never picks up a token
  AST_BYPASS_STAYS_EMPTY: assert property (@(posedge clk) disable iff (rst)
    (bypass && !segHasTok) |=> !segHasTok); // R7

endmodule

// File: rtl/tdl_datapath.sv
module tdl_datapath
  import tdl_pkg::*;
#(
  parameter int NUM_STAGES = 14,
  parameter int SEG_COUNT  = 4,
  parameter int BASE_LEN   = 2,
  localparam int SEL_W     = NUM_STAGES * SEG_COUNT
) (
  input  logic             clk,
  input  logic             rst,
  input  tdlStrobe_t       strb,
  input  logic             upIn,
  input  logic [SEL_W-1:0] delaySel,
  output logic             reqOut,
  output logic             upOut,
  output logic             tokEmerge,
  output logic             lineHasTok
);

  logic [SEL_W-1:0] cfgQ;
  tdlTok_t          link [SEL_W+1];
  logic [SEL_W-1:0] segBusy;

  always_ff @(posedge clk) begin
    if (rst)               cfgQ <= '0;
    else if (strb.loadCfg) cfgQ <= delaySel;
  end

  assign link[0] = '{vld: strb.acceptTok, up: upIn};

  for (genvar s = 0; s < NUM_STAGES; s++) begin : gStage
    for (genvar k = 0; k < SEG_COUNT; k++) begin : gSeg
      localparam int IDX = s * SEG_COUNT + k;
      localparam int LEN = BASE_LEN << k;
      tdl_segment #(.LEN(LEN)) uSeg (
        .clk      (clk),
        .rst      (rst),
        .bypass   (!cfgQ[IDX]),
        .segIn    (link[IDX]),
        .segOut   (link[IDX+1]),
        .segHasTok(segBusy[IDX])
      );
    end
  end

  assign tokEmerge  = link[SEL_W].vld;
  assign lineHasTok = |segBusy;

  // output reshaping register: one clean pulse per token, held direction bit
  always_ff @(posedge clk) begin
    if (rst) begin
      reqOut <= 1'b0;
      upOut  <= 1'b0;
    end else begin
      reqOut <= link[SEL_W].vld;
      if (link[SEL_W].vld) upOut <= link[SEL_W].up;
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    lineHasTok |-> !strb.loadCfg); // R7

  AST_UP_HOLD: assert property (@(posedge clk) disable iff (rst)
    !reqOut |-> $stable(upOut)); // R4

endmodule

// File: rtl/tdl_control.sv
module tdl_control
  import tdl_pkg::*;
#(
  parameter int MAX_DELAY = 420,
  localparam int CNT_W    = $clog2(MAX_DELAY + 2)
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       reqIn,
  input  logic       tokEmerge,
  output tdlStrobe_t strb,
  output logic       busy
);

  logic [CNT_W-1:0] inFlight;

  always_ff @(posedge clk) begin
    if (rst) inFlight <= '0;
    else     inFlight <= inFlight + CNT_W'(reqIn) - CNT_W'(tokEmerge);
  end

  assign busy           = (inFlight != '0);
  assign strb.acceptTok = reqIn;
  assign strb.loadCfg   = !busy && !reqIn;

  AST_POP_HAS_SOURCE: assert property (@(posedge clk) disable iff (rst)
    tokEmerge |-> (busy || reqIn)); // R8

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
    (inFlight <= CNT_W'(MAX_DELAY)) || tokEmerge); // R5

endmodule

// File: rtl/token_delay_line.sv
module token_delay_line
  import tdl_pkg::*;
#(
  parameter int NUM_STAGES = 14,
  parameter int SEG_COUNT  = 4,
  parameter int BASE_LEN   = 2,
  localparam int SEL_W     = NUM_STAGES * SEG_COUNT,
  localparam int MAX_DELAY = NUM_STAGES * BASE_LEN * ((1 << SEG_COUNT) - 1)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             reqIn,
  input  logic             upIn,
  input  logic [SEL_W-1:0] delaySel,
  output logic             reqOut,
  output logic             upOut,
  output logic             busy
);

  tdlStrobe_t strb;
  logic       tokEmerge;
  logic       lineHasTok;

  tdl_control #(.MAX_DELAY(MAX_DELAY)) uCtrl (
    .clk      (clk),
    .rst      (rst),
    .reqIn    (reqIn),
    .tokEmerge(tokEmerge),
    .strb     (strb),
    .busy     (busy)
  );

  tdl_datapath #(
    .NUM_STAGES(NUM_STAGES),
    .SEG_COUNT (SEG_COUNT),
    .BASE_LEN  (BASE_LEN)
  ) uDp (
    .clk       (clk),
    .rst       (rst),
    .strb      (strb),
    .upIn      (upIn),
    .delaySel  (delaySel),
    .reqOut    (reqOut),
    .upOut     (upOut),
    .tokEmerge (tokEmerge),
    .lineHasTok(lineHasTok)
  );

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (rst)
    (!busy && !reqIn) |=> !reqOut); // R8

endmodule

// File: tb/tb_token_delay_line.sv
module tb_token_delay_line;

  localparam int CLK_PERIOD = 10;
  localparam int SEL_W = 56;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reqIn = 1'b0;
  logic upIn = 1'b0;
  logic [SEL_W-1:0] delaySel = '0;
  logic reqOut, upOut, busy;

  int errors = 0;
  int checks = 0;
  string phaseTag = "R1";

  token_delay_line dut (
    .clk(clk), .rst(rst), .reqIn(reqIn), .upIn(upIn),
    .delaySel(delaySel), .reqOut(reqOut), .upOut(upOut), .busy(busy)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // ---------------- reference model ----------------
  int edgeNo = 0;
  int cfgDelay = 0;
  int exitQ[$];
  bit upQ[$];
  bit expReq = 0, expUp = 0, expBusy = 0;

  function automatic int sumDelay(logic [SEL_W-1:0] sel);
    int d = 0;
    for (int s = 0; s < 14; s++)
      for (int k = 0; k < 4; k++)
        if (sel[s*4+k]) d += (2 << k);
    return d;
  endfunction

  always @(posedge clk) begin
    edgeNo++;
    if (rst) begin
      exitQ.delete(); upQ.delete();
      cfgDelay = 0; expReq = 0; expUp = 0; expBusy = 0;
    end else begin
      automatic bit loadNow = (exitQ.size() == 0) && !reqIn;
      if (reqIn) begin
        exitQ.push_back(edgeNo + cfgDelay);
        upQ.push_back(upIn);
      end
      expReq = 0;
      if (exitQ.size() != 0 && exitQ[0] == edgeNo) begin
        void'(exitQ.pop_front());
        expUp = upQ.pop_front();
        expReq = 1;
      end
      if (loadNow) cfgDelay = sumDelay(delaySel);
      expBusy = (exitQ.size() != 0);
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  bit running = 0;
  always @(negedge clk) begin
    if (running) begin
      chk(phaseTag, "reqOut", int'(reqOut), int'(expReq));
      chk(phaseTag, "upOut", int'(upOut), int'(expUp));
      chk(phaseTag, "busy", int'(busy), int'(expBusy));
    end
  end

  // ---------------- stimulus ----------------
  task automatic sendTok(bit up, int gapAfter);
    reqIn = 1'b1; upIn = up;
    @(negedge clk);
    reqIn = 1'b0; upIn = 1'b0;
    repeat (gapAfter) @(negedge clk);
  endtask

  task automatic drain();
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    logic [SEL_W-1:0] selA, selB;
    selA = (56'h1 << 0) | (56'h1 << 15) | (56'hF << 52);   // D = 48
    selB = (56'h1 << 21) | (56'h1 << 30);                   // D = 12

    repeat (3) @(negedge clk);
    chk("R1", "reqOut in reset", int'(reqOut), 0);
    chk("R1", "upOut in reset", int'(upOut), 0);
    chk("R1", "busy in reset", int'(busy), 0);
    rst = 1'b0;
    running = 1;
    @(negedge clk);

    // zero delay
    phaseTag = "R6";
    reqIn = 1'b1; upIn = 1'b1;
    @(negedge clk);
    reqIn = 1'b0; upIn = 1'b0;
    chk("R6", "pass-through pulse", int'(reqOut), 1);
    chk("R6", "pass-through up", int'(upOut), 1);
    repeat (3) @(negedge clk);

    // programmed delay, mixed gaps and bits
    phaseTag = "R2";
    delaySel = selA;
    repeat (2) @(negedge clk);
    sendTok(1, 3);
    chk("R8", "busy while in flight", int'(busy), 1);
    sendTok(0, 1);
    phaseTag = "R3";
    sendTok(1, 0);
    sendTok(0, 0);
    sendTok(1, 6);
    phaseTag = "R4";
    sendTok(0, 2);
    sendTok(1, 9);
    drain();
    chk("R8", "idle after drain", int'(busy), 0);

    // select change while busy has no effect until empty
    phaseTag = "R7";
    sendTok(1, 4);
    delaySel = selB;
    sendTok(0, 5);
    sendTok(1, 2);
    drain();
    sendTok(1, 1);
    sendTok(0, 3);
    drain();

    // continuous stream
    phaseTag = "R5";
    for (int i = 0; i < 60; i++) begin
      reqIn = 1'b1; upIn = (i % 3 == 1);
      @(negedge clk);
    end
    reqIn = 1'b0; upIn = 1'b0;
    drain();

    // maximum delay
    phaseTag = "R9";
    delaySel = '1;
    repeat (2) @(negedge clk);
    sendTok(1, 0);
    sendTok(0, 10);
    sendTok(1, 2);
    drain();

    running = 0;
    finishRun();
  end

endmodule